// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block collects eighteen interrupt request lines and turns them into one vector request for a single processor. Each source belongs to one of six groups, and every group carries a 2-bit priority level set through a small configuration write port. A rising edge on a request line latches a pending flag. Pending flags are qualified by per-source enables and by a global enable. The highest-level eligible request is offered to the processor as a 5-bit source index with a valid flag, and the offer is held until the processor acknowledges it.

Nesting is tracked by level. An in-service stack keeps one bit per level. An acknowledge sets the bit for the level it accepted, and a return strobe clears the highest set bit. A new request is offered only when its level is strictly above the highest level in service. A fixed subset of sources (the I/O and sleep-timer lines) can raise a wake output while the system sleeps.

The control is a two-state machine. In ST_IDLE, the transition "offer" to ST_OFFER is taken when an eligible winner exists: global enable high, winner level above the in-service level, or stack empty. In ST_OFFER, the transition "accept" back to ST_IDLE is taken on the acknowledge.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, irq_valid and wake are low, all pending flags, enables, priority fields and in-service bits are zero.
- R2: A pending flag is set by a rising edge of its request line only; a line held high after its flag was cleared does not set it again.
- R3: Source s belongs to group s mod 6. The priority of group g is cfg_wdata[2g+1:2g] written with cfg_addr=1, where 3 is the highest level and 0 the lowest.
- R4: Among eligible pending sources the highest level wins. At equal level, the lowest source index wins.
- R5: A source whose enable bit (written with cfg_addr=0, bit s for source s) is low is not offered, but its pending flag is kept and is offered once the enable is set.
- R6: While gie is low no new offer is made, and pending flags still accumulate.
- R7: irq_valid, once high, stays high with an unchanged irq_vec until irq_ack. The acknowledge clears the pending flag of the offered source.
- R8: An offer is made only when the winner's level is strictly above the highest in-service level. irq_ack sets the in-service bit of the accepted level, and irq_reti clears the highest set in-service bit.
- R9: Writing cfg_addr=2 clears the pending flag of every source whose cfg_wdata bit is one.
- R10: wake is high exactly when sleep is high and some enabled source in the wake subset (sources 0 to 3) is pending, independent of gie.
- R11: With the controller idle and a request eligible, irq_valid rises on the second rising clock edge after the request line goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 18 | Request lines, one per source |
| gie | input | 1 | Global enable for offers |
| sleep | input | 1 | System is in a light sleep mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 enables, 1 group priorities, 2 pending clear |
| cfg_wdata | input | 18 | Configuration write data |
| irq_ack | input | 1 | Processor accepts the offered vector |
| irq_reti | input | 1 | Return-from-interrupt strobe |
| irq_valid | output | 1 | A vector is offered |
| irq_vec | output | 5 | Offered source index |
| wake | output | 1 | Wake request during sleep |

## Verification
On every cycle, the assertions check several properties. An offer holds steady until it is acknowledged. No offer begins while gie is low. A new offer always outranks the in-service level. The vector stays within range. A write-one-to-clear empties the flag unless a new edge arrives. Wake only rises during sleep. The bench scenarios are needed for the properties that depend on history. These cover which source wins under a given group priority map, and the lowest-index tie break. They also cover re-offering a masked or gated request after its enable returns, and the absence of re-pending on a held line. Finally, they cover the two-edge latency and the effect of return strobes on nested levels.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } ctl_state_t;

    function automatic int group_of(input int src, input int n_grp);
        return src % n_grp;
    endfunction
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int N_SRC = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] sw_clr,
    input  logic [N_SRC-1:0] ack_clr,
    output logic [N_SRC-1:0] pend
);
    logic [N_SRC-1:0] req_q;
    logic [N_SRC-1:0] rise;

    assign rise = req & ~req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= req;
            pend  <= (pend & ~sw_clr & ~ack_clr) | rise;
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_chk
        a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr[i] && !rise[i]) |=> !pend[i]);
    end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
    parameter int N_SRC = 18,
    parameter int N_GRP = 6,
    parameter int LVL_W = 2,
    parameter int IDX_W = 5
) (
    input  logic [N_SRC-1:0]       cand,
    input  logic [LVL_W*N_GRP-1:0] prio,
    output logic                   found,
    output logic [IDX_W-1:0]       idx,
    output logic [LVL_W-1:0]       lvl
);
    logic [LVL_W-1:0] l_s;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        lvl   = '0;
        l_s   = '0;
        for (int s = N_SRC - 1; s >= 0; s--) begin
            l_s = prio[LVL_W*irq_pkg::group_of(s, N_GRP) +: LVL_W];
            if (cand[s] && (!found || l_s >= lvl)) begin
                found = 1'b1;
                idx   = IDX_W'(s);
                lvl   = l_s;
            end
        end
    end
endmodule

// File: rtl/irq_nest.sv
module irq_nest #(
    parameter int N_LVL = 4,
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic             any,
    output logic [LVL_W-1:0] top
);
    logic [N_LVL-1:0] stack_q;
    logic [N_LVL-1:0] popped;

    always_comb begin
        top = '0;
        for (int l = 0; l < N_LVL; l++) begin
            if (stack_q[l]) top = LVL_W'(l);
        end
    end

    assign any = |stack_q;

    always_comb begin
        popped = stack_q;
        if (pop && any) popped[top] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stack_q <= '0;
        end else begin
            stack_q <= popped;
            if (push) stack_q[push_lvl] <= 1'b1;
        end
    end

    a_r8_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && any) |=> (!any || top < $past(top)));
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
    parameter int          N_SRC     = 18,
    parameter int          N_GRP     = 6,
    parameter int          N_LVL     = 4,
    parameter logic [17:0] WAKE_MASK = 18'h0000F
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SRC-1:0]         irq_req,
    input  logic                     gie,
    input  logic                     sleep,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_addr,
    input  logic [N_SRC-1:0]         cfg_wdata,
    input  logic                     irq_ack,
    input  logic                     irq_reti,
    output logic                     irq_valid,
    output logic [$clog2(N_SRC)-1:0] irq_vec,
    output logic                     wake
);
    import irq_pkg::*;

    localparam int LVL_W = $clog2(N_LVL);
    localparam int IDX_W = $clog2(N_SRC);
    localparam int PRIO_W = LVL_W * N_GRP;

    ctl_state_t       state_q, state_d;
    logic [N_SRC-1:0] en_q;
    logic [PRIO_W-1:0] prio_q;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] sw_clr;
    logic [N_SRC-1:0] ack_clr;
    logic             win_found;
    logic [IDX_W-1:0] win_idx;
    logic [LVL_W-1:0] win_lvl;
    logic             nest_any;
    logic [LVL_W-1:0] nest_top;
    logic             can_take;
    logic             accept;
    logic [IDX_W-1:0] vec_q;
    logic [LVL_W-1:0] lvl_q;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            prio_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == 2'd0) en_q   <= cfg_wdata;
            if (cfg_addr == 2'd1) prio_q <= cfg_wdata[PRIO_W-1:0];
        end
    end

    assign sw_clr  = (cfg_we && cfg_addr == 2'd2) ? cfg_wdata : '0;
    assign accept  = (state_q == ST_OFFER) && irq_ack;
    assign ack_clr = accept ? (N_SRC'(1) << vec_q) : '0;

    irq_pend #(.N_SRC(N_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(irq_req),
        .sw_clr(sw_clr), .ack_clr(ack_clr), .pend(pend)
    );

    irq_arb #(.N_SRC(N_SRC), .N_GRP(N_GRP), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
        .cand(pend & en_q), .prio(prio_q),
        .found(win_found), .idx(win_idx), .lvl(win_lvl)
    );

    irq_nest #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_nest (
        .clk(clk), .rst_n(rst_n), .push(accept), .push_lvl(lvl_q),
        .pop(irq_reti), .any(nest_any), .top(nest_top)
    );

    assign can_take = gie && win_found && (!nest_any || win_lvl > nest_top);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (can_take) state_d = ST_OFFER;
            ST_OFFER: if (irq_ack)  state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            lvl_q <= '0;
        end else if (state_q == ST_IDLE && can_take) begin
            vec_q <= win_idx;
            lvl_q <= win_lvl;
        end
    end

    assign irq_valid = (state_q == ST_OFFER);
    assign irq_vec   = vec_q;
    assign wake      = sleep && |(pend & en_q & WAKE_MASK[N_SRC-1:0]);

    a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_vec)));
    a_r7_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (int'(irq_vec) < N_SRC));
    a_r6_gie_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie && !irq_valid) |=> !irq_valid);
    a_r8_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> (!$past(nest_any) || lvl_q > $past(nest_top)));
    a_r10_wake_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> sleep);
endmodule

// File: tb/irq_ctrl_top_tb.sv
module irq_ctrl_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 18;
    localparam logic [17:0] WMASK = 18'h0000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] irq_req = '0;
    logic        gie = 1'b0;
    logic        sleep = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [17:0] cfg_wdata = '0;
    logic        irq_ack = 1'b0;
    logic        irq_reti = 1'b0;
    logic        irq_valid;
    logic [4:0]  irq_vec;
    logic        wake;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model
    logic [17:0] m_pend = '0, m_en = '0, m_req = '0;
    logic [11:0] m_prio = '0;
    logic [3:0]  m_stack = '0;
    logic        m_valid = 1'b0;
    logic [4:0]  m_vec = '0;
    logic [1:0]  m_lvl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .gie(gie), .sleep(sleep),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .irq_ack(irq_ack), .irq_reti(irq_reti),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .wake(wake)
    );

    function automatic logic [1:0] src_lvl(input int s);
        return m_prio[2*(s % 6) +: 2];
    endfunction

    function automatic int top_lvl();
        int t = -1;
        for (int l = 0; l < 4; l++) if (m_stack[l]) t = l;
        return t;
    endfunction

    // returns -1 when nothing eligible, else source index
    function automatic int winner();
        int w = -1;
        for (int s = 0; s < NS; s++) begin
            if (m_pend[s] && m_en[s]) begin
                if (w < 0 || src_lvl(s) > src_lvl(w)) w = s;
            end
        end
        if (w >= 0 && int'(src_lvl(w)) <= top_lvl()) w = -1;
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic model_offer();
        int w;
        w = winner();
        if (!m_valid && gie && w >= 0) begin
            m_valid = 1'b1;
            m_vec = 5'(w);
            m_lvl = src_lvl(w);
        end
    endtask

    task automatic settle();
        repeat (3) tick();
        model_offer();
    endtask

    task automatic compare(input string tag);
        check({tag, " valid"}, 32'(irq_valid), 32'(m_valid));
        if (m_valid) check({tag, " vec"}, 32'(irq_vec), 32'(m_vec));
        check("R10 wake", 32'(wake), 32'(sleep && |(m_pend & m_en & WMASK)));
    endtask

    task automatic drive_req(input logic [17:0] v);
        irq_req = v;
        m_pend = m_pend | (v & ~m_req);
        m_req = v;
        tick();
    endtask

    task automatic pulse(input logic [17:0] v);
        drive_req(v);
        drive_req('0);
        settle();
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [17:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
        if (a == 2'd0) m_en = d;
        if (a == 2'd1) m_prio = d[11:0];
        if (a == 2'd2) m_pend = m_pend & ~d;
        settle();
    endtask

    task automatic do_ack();
        if (!m_valid) return;
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        m_pend[m_vec] = 1'b0;
        m_stack[m_lvl] = 1'b1;
        m_valid = 1'b0;
        settle();
    endtask

    task automatic do_reti();
        int t;
        irq_reti = 1'b1;
        tick();
        irq_reti = 1'b0;
        t = top_lvl();
        if (t >= 0) m_stack[t] = 1'b0;
        settle();
    endtask

    task automatic set_gie(input logic g);
        gie = g;
        settle();
    endtask

    task automatic drain();
        for (int k = 0; k < 12; k++) begin
            do_ack();
            do_reti();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) tick();
        // R1: reset state
        check("R1 valid", 32'(irq_valid), 32'd0);
        check("R1 wake", 32'(wake), 32'd0);
        rst_n = 1'b1;
        tick();
        sleep = 1'b1;
        pulse(18'h0000F);
        check("R1 nothing enabled after reset", 32'(irq_valid | wake), 32'd0);
        sleep = 1'b0;
        cfg_write(2'd2, '1);

        // groups: g0=1 g1=2 g2=3 g3=0 g4=2 g5=1
        cfg_write(2'd1, 18'({2'd1, 2'd2, 2'd0, 2'd3, 2'd2, 2'd1}));
        cfg_write(2'd0, '1);
        set_gie(1'b1);

        // R4 tie at level 2: sources 7 and 1 (group 1) -> 1
        pulse(18'(1 << 7) | 18'(1 << 1));
        check("R4 tie lowest index", 32'(irq_vec), 32'd1);
        compare("R4");
        drain();

        // R3/R4: source 2 (group 2, level 3) beats 4 (group 4, level 2) and 0
        pulse(18'(1 << 4) | 18'(1 << 0) | 18'(1 << 2));
        check("R3 group level map", 32'(irq_vec), 32'd2);
        drain();

        // R11 latency
        drive_req(18'(1 << 9));
        check("R11 not yet", 32'(irq_valid), 32'd0);
        drive_req('0);
        check("R11 second edge", 32'(irq_valid), 32'd1);
        settle();
        compare("R11");
        drain();

        // R2 held line does not re-pend
        drive_req(18'(1 << 5));
        settle();
        check("R2 offered", 32'(irq_vec), 32'd5);
        do_ack();
        do_reti();
        check("R2 held line no repeat", 32'(irq_valid), 32'd0);
        drive_req('0);
        settle();
        compare("R2");

        // R5 enable mask
        cfg_write(2'd0, ~18'(1 << 3));
        pulse(18'(1 << 3));
        check("R5 masked", 32'(irq_valid), 32'd0);
        cfg_write(2'd0, '1);
        check("R5 offered after enable", 32'(irq_vec), 32'd3);
        drain();

        // R6 gie low accumulates
        set_gie(1'b0);
        pulse(18'(1 << 11));
        check("R6 gated", 32'(irq_valid), 32'd0);
        set_gie(1'b1);
        check("R6 kept pending", 32'(irq_vec), 32'd11);
        // R7 hold while other requests arrive
        pulse(18'(1 << 8));
        check("R7 vector held", 32'(irq_vec), 32'd11);
        drain();

        // R8 nesting: take level 1 (src 0), equal level 1 (src 6) waits, level 3 (src 14) pre-empts
        pulse(18'(1 << 0));
        do_ack();
        pulse(18'(1 << 6));
        check("R8 equal level waits", 32'(irq_valid), 32'd0);
        pulse(18'(1 << 14));
        check("R8 higher preempts", 32'(irq_vec), 32'd14);
        do_ack();
        do_reti();
        check("R8 still level1 in service", 32'(irq_valid), 32'd0);
        do_reti();
        check("R8 after second return", 32'(irq_vec), 32'd6);
        drain();

        // R9 write-one-to-clear
        set_gie(1'b0);
        pulse(18'(1 << 12) | 18'(1 << 13));
        cfg_write(2'd2, 18'(1 << 12));
        set_gie(1'b1);
        check("R9 cleared one remains", 32'(irq_vec), 32'd13);
        drain();

        // R10 wake subset
        set_gie(1'b0);
        sleep = 1'b1;
        pulse(18'(1 << 10));
        check("R10 non-wake source", 32'(wake), 32'd0);
        pulse(18'(1 << 2));
        check("R10 wake source", 32'(wake), 32'd1);
        sleep = 1'b0;
        tick();
        check("R10 awake", 32'(wake), 32'd0);
        set_gie(1'b1);
        drain();

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 10);
            case (op)
                0, 1, 2: pulse(18'($urandom & $urandom & $urandom));
                3, 4:    do_ack();
                5:       do_reti();
                6:       set_gie(($urandom % 4) != 0);
                7:       cfg_write(2'd0, 18'($urandom | $urandom));
                8:       cfg_write(2'd1, 18'($urandom));
                default: begin
                    if ($urandom % 2) cfg_write(2'd2, 18'($urandom & $urandom));
                    else begin sleep = $urandom % 2; settle(); end
                end
            endcase
            compare("R4 R7 R8 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule